// File: doc/BRIEF.md
# Compare / Capture / PWM Channel

This block is a single channel of a counter array. A shared timebase supplies a 16-bit count value and two strobes. The first strobe marks a count step. The second marks the cycle in which the low half of the count has just wrapped to zero. The channel holds a 16-bit compare value, written one byte at a time, and a mode byte. From these it does four jobs:

- it raises an event when the count reaches the compare value (a software timer);
- it flips its external pin on such a match (fast toggle output);
- it generates an 8-bit pulse-width waveform whose duty is double-buffered;
- it records the count when an enabled edge arrives on its input pin.

A parameter selects the last-channel variant. In that variant a match can request a system reset in place of the event, which lets the channel serve as a watchdog.

Software reaches three byte registers through a simple select/write port: mode, compare low and compare high. A fourth read-only select returns the latched pin transitions. The event flag is cleared by a separate strobe. The interrupt request is the event flag gated by the mode's interrupt-enable bit.

Top module: `ccp_channel`

## Requirements
- R1: After reset the event flag, interrupt request, reset request and pin output are 0, and every readable register reads 0.
- R2: In a cycle with `cnt_tick` high, comparator enable (mode bit 0) set and `cnt_value` equal to {compare high, compare low}, the event flag is 1 from the next cycle on. No flag is raised without `cnt_tick` or with the comparator disabled.
- R3: With toggle (mode bit 4) set and PWM off, each match inverts `pin_out`, and a non-matching step leaves it unchanged.
- R4: While match (mode bit 3) or toggle (mode bit 4) is set, a write to compare low (`wr_sel`=1) clears mode bit 0 and a write to compare high (`wr_sel`=2) sets it. With both bits clear, such writes leave mode bit 0 alone. A mode write uses `wr_sel`=0.
- R5: With PWM (mode bit 5) set, `low_wrap` copies compare high into compare low. Without PWM, `low_wrap` leaves compare low unchanged.
- R6: With PWM set, `pin_out` is 0 while the count's low byte is below the duty and 1 otherwise. The duty is compare low, or compare high in a cycle where `low_wrap` reloads it.
- R7: Rising and falling transitions of `pin_in` are latched in bits 0 and 1 of the status read (`rd_sel`=3). A mode write that changes the mode value clears both latches; a mode write of the same value does not.
- R8: A rising edge with mode bit 1 set, or a falling edge with mode bit 2 set, copies `cnt_value` into the compare register and sets the event flag. An edge of the other polarity captures nothing.
- R9: `irq` is the event flag gated by interrupt enable (mode bit 6). `flag_clr` clears the flag, and a set in the same cycle wins.
- R10: On the last-channel variant with `wdt_en` high, a match gives a one-cycle `sys_rst_req` pulse in the next cycle and does not set the event flag. On other channels `wdt_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_value | input | 16 | Shared counter value |
| cnt_tick | input | 1 | Counter stepped; qualifies the compare |
| low_wrap | input | 1 | Counter low byte has just wrapped to zero |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 compare low, 2 compare high |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 mode, 1 low, 2 high, 3 edge status |
| rd_data | output | 8 | Read data |
| flag_clr | input | 1 | Clears the event flag |
| wdt_en | input | 1 | Watchdog enable (last-channel variant only) |
| pin_in | input | 1 | Sampled external pin level |
| pin_out | output | 1 | External pin drive |
| evt_flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The hardest situation to reach from the ports is a duty reload that coincides with a count whose low byte is zero. The pin level in that cycle has to use the newly loaded duty, not the stale one. The bench arranges this by pulsing `low_wrap` together with a zero count while the two compare bytes differ, and checks the pin in that same cycle. Only after that does it sweep all 256 low-byte values for each of several duties. The auto-toggling comparator enable is the other hard case: the bench reads the mode byte back after each byte write, first with match/toggle on and then with both off.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int MODE_W  = 7;
  localparam int MB_ECOM = 0;
  localparam int MB_CAPP = 1;
  localparam int MB_CAPN = 2;
  localparam int MB_MAT  = 3;
  localparam int MB_TOG  = 4;
  localparam int MB_PWM  = 5;
  localparam int MB_EIE  = 6;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CLO  = 2'd1;
  localparam logic [1:0] SEL_CHI  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/ccp_edge.sv
module ccp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic clr,
  output logic rise,
  output logic fall,
  output logic rise_seen,
  output logic fall_seen
);
  logic pin_prev;

  assign rise = pin_in & ~pin_prev;
  assign fall = ~pin_in & pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev  <= 1'b0;
      rise_seen <= 1'b0;
      fall_seen <= 1'b0;
    end else begin
      pin_prev <= pin_in;
      if (clr) begin
        rise_seen <= 1'b0;
        fall_seen <= 1'b0;
      end else begin
        rise_seen <= rise_seen | rise;
        fall_seen <= fall_seen | fall;
      end
    end
  end
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
  parameter int HALF_W = 8,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic [CNT_W-1:0] cnt_value,
  input  logic [CNT_W-1:0] cap_q,
  input  logic             cnt_tick,
  input  logic             low_wrap,
  input  logic             ecom_en,
  input  logic             pwm_en,
  output logic             match_hit,
  output logic             pwm_reload,
  output logic             pwm_level
);
  function automatic logic f_equal(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a == b);
  endfunction

  function automatic logic f_pwm_high(input logic [HALF_W-1:0] lo, input logic [HALF_W-1:0] duty);
    return !(lo < duty);
  endfunction

  logic [HALF_W-1:0] duty_eff;

  assign match_hit  = cnt_tick & ecom_en & f_equal(cnt_value, cap_q);
  assign pwm_reload = low_wrap & pwm_en;
  assign duty_eff   = pwm_reload ? cap_q[CNT_W-1:HALF_W] : cap_q[HALF_W-1:0];
  assign pwm_level  = f_pwm_high(cnt_value[HALF_W-1:0], duty_eff);
endmodule

// File: rtl/ccp_regs.sv
module ccp_regs
  import ccp_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              cap_load,
  input  logic [CNT_W-1:0]  cap_value,
  input  logic              pwm_reload,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic              mode_changed
);
  logic [HALF_W-1:0] cap_lo, cap_hi;
  logic wr_mode, wr_lo, wr_hi, auto_ecom;

  assign wr_mode      = wr_en && (wr_sel == SEL_MODE);
  assign wr_lo        = wr_en && (wr_sel == SEL_CLO);
  assign wr_hi        = wr_en && (wr_sel == SEL_CHI);
  assign auto_ecom    = mode_q[MB_MAT] | mode_q[MB_TOG];
  assign mode_changed = wr_mode && (wr_data[MODE_W-1:0] != mode_q);
  assign cap_q        = {cap_hi, cap_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= wr_data[MODE_W-1:0];
    end else if (auto_ecom && wr_lo) begin
      mode_q[MB_ECOM] <= 1'b0;
    end else if (auto_ecom && wr_hi) begin
      mode_q[MB_ECOM] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else begin
      if (wr_lo)           cap_lo <= wr_data;
      else if (cap_load)   cap_lo <= cap_value[HALF_W-1:0];
      else if (pwm_reload) cap_lo <= cap_hi;

      if (wr_hi)           cap_hi <= wr_data;
      else if (cap_load)   cap_hi <= cap_value[CNT_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int HALF_W  = 8,
  parameter bit IS_LAST = 1'b1,
  localparam int CNT_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              cnt_tick,
  input  logic              low_wrap,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [HALF_W-1:0] rd_data,
  input  logic              flag_clr,
  input  logic              wdt_en,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              evt_flag,
  output logic              irq,
  output logic              sys_rst_req
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cap_q;
  logic mode_changed, rise, fall, rise_seen, fall_seen;
  logic match_hit, cap_hit, pwm_reload, pwm_level, wdt_active;
  logic flag_set, tog_q;

  ccp_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cap_load(cap_hit), .cap_value(cnt_value), .pwm_reload(pwm_reload),
    .mode_q(mode_q), .cap_q(cap_q), .mode_changed(mode_changed)
  );

  ccp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clr(mode_changed),
    .rise(rise), .fall(fall), .rise_seen(rise_seen), .fall_seen(fall_seen)
  );

  ccp_compare #(.HALF_W(HALF_W)) u_cmp (
    .cnt_value(cnt_value), .cap_q(cap_q), .cnt_tick(cnt_tick), .low_wrap(low_wrap),
    .ecom_en(mode_q[MB_ECOM]), .pwm_en(mode_q[MB_PWM]),
    .match_hit(match_hit), .pwm_reload(pwm_reload), .pwm_level(pwm_level)
  );

  generate
    if (IS_LAST) begin : g_wdt
      assign wdt_active = wdt_en;
    end else begin : g_no_wdt
      assign wdt_active = wdt_en & 1'b0;
    end
  endgenerate

  assign cap_hit  = (mode_q[MB_CAPP] & rise) | (mode_q[MB_CAPN] & fall);
  assign flag_set = (match_hit & ~wdt_active) | cap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_flag    <= 1'b0;
      tog_q       <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      if (flag_set)      evt_flag <= 1'b1;
      else if (flag_clr) evt_flag <= 1'b0;
      if (match_hit && !wdt_active && mode_q[MB_TOG]) tog_q <= ~tog_q;
      sys_rst_req <= match_hit & wdt_active;
    end
  end

  assign pin_out = mode_q[MB_PWM] ? pwm_level : tog_q;
  assign irq     = evt_flag & mode_q[MB_EIE];

  always_comb begin
    case (rd_sel)
      SEL_MODE: rd_data = {{(HALF_W-MODE_W){1'b0}}, mode_q};
      SEL_CLO:  rd_data = cap_q[HALF_W-1:0];
      SEL_CHI:  rd_data = cap_q[CNT_W-1:HALF_W];
      default:  rd_data = {{(HALF_W-2){1'b0}}, fall_seen, rise_seen};
    endcase
  end
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk
  import ccp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              flag_clr,
  input logic [MODE_W-1:0] mode_q,
  input logic              match_hit,
  input logic              cap_hit,
  input logic              wdt_active,
  input logic              evt_flag,
  input logic              irq,
  input logic              pin_out,
  input logic              sys_rst_req
);
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && !wdt_active) |=> evt_flag); // R2
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && !wdt_active && mode_q[MB_TOG] && !mode_q[MB_PWM] && !wr_en)
      |=> (pin_out != $past(pin_out))); // R3
  AST_LOW_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CLO && (mode_q[MB_MAT] || mode_q[MB_TOG])) |=> !mode_q[MB_ECOM]); // R4
  AST_HIGH_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CHI && (mode_q[MB_MAT] || mode_q[MB_TOG])) |=> mode_q[MB_ECOM]); // R4
  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> evt_flag); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_flag); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_hit && !cap_hit) |=> !evt_flag); // R9
  AST_RESET_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(match_hit && wdt_active)); // R10
endmodule

bind ccp_channel ccp_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .flag_clr(flag_clr),
  .mode_q(mode_q), .match_hit(match_hit), .cap_hit(cap_hit), .wdt_active(wdt_active),
  .evt_flag(evt_flag), .irq(irq), .pin_out(pin_out), .sys_rst_req(sys_rst_req)
);

// File: tb/sim_ccp_channel.sv
module sim_ccp_channel;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cnt_value = '0;
  logic cnt_tick = 0, low_wrap = 0, wr_en = 0, flag_clr = 0, wdt_en = 0, pin_in = 0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd0, rd1;
  logic pin0, pin1, flag0, flag1, irq0, irq1, rst0, rst1;
  int tests = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  ccp_channel #(.HALF_W(8), .IS_LAST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cnt_tick(cnt_tick), .low_wrap(low_wrap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd0),
    .flag_clr(flag_clr), .wdt_en(wdt_en), .pin_in(pin_in), .pin_out(pin0),
    .evt_flag(flag0), .irq(irq0), .sys_rst_req(rst0));

  ccp_channel #(.HALF_W(8), .IS_LAST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cnt_tick(cnt_tick), .low_wrap(low_wrap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd1),
    .flag_clr(flag_clr), .wdt_en(wdt_en), .pin_in(pin_in), .pin_out(pin1),
    .evt_flag(flag1), .irq(irq1), .sys_rst_req(rst1));

  task automatic tick();
    @(posedge clk); #(PERIOD/4);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    rd_sel = s; #1; d = rd0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; tick(); flag_clr = 0;
  endtask

  task automatic step(input logic [15:0] v);
    cnt_value = v; cnt_tick = 1; tick(); cnt_tick = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #(PERIOD/4); rst_n = 1;
    // R1 reset state
    chk("R1 flag", flag0, 0); chk("R1 irq", irq0, 0);
    chk("R1 rst_req", rst0, 0); chk("R1 pin", pin0, 0);
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d); chk("R1 register", d, 0);
    end

    // R4 auto comparator enable (mode bit0; match bit3, toggle bit4)
    wr(0, 8'h09);
    wr(1, 8'h34); rd(0, d); chk("R4 low write clears enable", d, 8'h08);
    wr(2, 8'h12); rd(0, d); chk("R4 high write sets enable", d, 8'h09);
    wr(0, 8'h01);
    wr(1, 8'h34); rd(0, d); chk("R4 no auto when match/toggle off", d, 8'h01);

    // R2 match sweep around 0x1234
    wr(0, 8'h09); wr(2, 8'h12);
    for (int v = 16'h1230; v <= 16'h1238; v++) begin
      step(v[15:0]);
      chk("R2 match sweep", flag0, (v == 16'h1234));
      chk("R9 irq off without enable", irq0, 0);
      clear_flag();
    end
    cnt_value = 16'h1234; tick();
    chk("R2 no flag without tick", flag0, 0);
    wr(1, 8'h34);
    step(16'h1234); chk("R2 no flag when comparator disabled", flag0, 0);

    // R3 toggle output
    wr(0, 8'h11); wr(1, 8'h00); wr(2, 8'h05);
    chk("R3 pin before", pin0, 0);
    step(16'h0500); chk("R3 first match toggles", pin0, 1); chk("R2 flag on toggle match", flag0, 1);
    step(16'h0501); chk("R3 non-match holds", pin0, 1);
    step(16'h0500); chk("R3 second match toggles", pin0, 0);
    step(16'h0500); chk("R3 third match toggles", pin0, 1);
    clear_flag();

    // R9 interrupt gating and clear priority (interrupt enable bit6)
    wr(0, 8'h49);
    step(16'h0500); chk("R9 flag", flag0, 1); chk("R9 irq", irq0, 1);
    clear_flag(); chk("R9 cleared flag", flag0, 0); chk("R9 cleared irq", irq0, 0);
    flag_clr = 1; step(16'h0500); flag_clr = 0;
    chk("R9 set wins over clear", flag0, 1);
    clear_flag();
    wr(0, 8'h09);
    step(16'h0500); chk("R9 irq masked", irq0, 0); chk("R9 flag unmasked", flag0, 1);
    clear_flag();

    // R10 watchdog variant
    wdt_en = 1;
    step(16'h0500);
    chk("R10 reset request on last", rst0, 1); chk("R10 no flag on last", flag0, 0);
    chk("R10 other channel flags", flag1, 1); chk("R10 other channel no request", rst1, 0);
    tick(); chk("R10 request is one pulse", rst0, 0);
    wdt_en = 0; clear_flag();

    // R5 no reload outside PWM mode (PWM bit5)
    wr(0, 8'h00); wr(1, 8'h11); wr(2, 8'h77);
    cnt_value = 16'h0000; low_wrap = 1; tick(); low_wrap = 0;
    rd(1, d); chk("R5 no reload without PWM", d, 8'h11);

    // R5/R6 PWM sweep over four duties
    wr(0, 8'h20);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] duty;
      duty = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : 8'hFF;
      wr(2, duty);
      cnt_value = 16'h0000; low_wrap = 1; #1;
      chk("R6 forwarded duty at wrap", pin0, (duty == 0));
      tick(); low_wrap = 0;
      rd(1, d); chk("R5 reload from high byte", d, duty);
      for (int c = 0; c < 256; c++) begin
        cnt_value = {8'h3C, c[7:0]}; #1;
        chk("R6 PWM level", pin0, (c[7:0] < duty) ? 1'b0 : 1'b1);
      end
      tick();
    end

    // R7 edge latches (status bit0 rise, bit1 fall)
    wr(0, 8'h00);
    pin_in = 1; tick(); rd(3, d); chk("R7 rise latched", d, 8'h01);
    pin_in = 0; tick(); rd(3, d); chk("R7 fall latched", d, 8'h03);
    wr(0, 8'h00); rd(3, d); chk("R7 same mode keeps latches", d, 8'h03);
    wr(0, 8'h40); rd(3, d); chk("R7 changed mode clears latches", d, 8'h00);

    // R8 capture (rising bit1, falling bit2)
    wr(0, 8'h02); clear_flag();
    cnt_value = 16'hABCD; pin_in = 1; tick();
    chk("R8 rising capture flag", flag0, 1);
    rd(1, d); chk("R8 captured low", d, 8'hCD);
    rd(2, d); chk("R8 captured high", d, 8'hAB);
    clear_flag();
    cnt_value = 16'h1111; pin_in = 0; tick(); tick();
    chk("R8 falling ignored when rising selected", flag0, 0);
    rd(1, d); chk("R8 value kept", d, 8'hCD);
    wr(0, 8'h04);
    pin_in = 1; tick(); tick(); chk("R8 rising ignored when falling selected", flag0, 0);
    cnt_value = 16'h2222; pin_in = 0; tick();
    chk("R8 falling capture flag", flag0, 1);
    rd(1, d); chk("R8 falling captured low", d, 8'h22);
    rd(2, d); chk("R8 falling captured high", d, 8'h22);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule